// File: doc/BRIEF.md
# SPI EEPROM Boot Copy Engine

This block brings a small 8-bit processor system out of reset. While it works, it holds the processor in reset and keeps the processor off the shared bus. It reads a fixed-length image from a fixed offset in an SPI serial EEPROM and writes each byte into main SRAM, starting at a fixed destination address. When the copy is complete, it gives the bus back and lets the processor start.

The processor reset output is generated by the engine itself and does not follow the engine's own reset. A synchronous `restart` input can therefore put the processor back into reset and repeat the whole copy without resetting the engine. When the engine is not copying, it releases its SPI outputs through an output-enable pin, so an external programmer can drive the EEPROM.

The image length, source offset, destination base and SCLK divider are parameters. The divider must be even and at least 2. The source offset must fit in 24 bits, and the destination range must fit in the 19-bit SRAM address space.

Top module: `spi_boot_copier`

## Requirements
- R1: From reset release until the copy completes, `cpu_res_n` is 0, `cpu_be` is 0, `busy` is 1 and `done` is 0. The same values hold while `rst_n` is low.
- R2: A copy keeps `spi_cs_n` low for the whole transfer. It first shifts out the 8-bit read opcode 0x03 and then the 24-bit `SRC_OFFSET`, both MSB first on `spi_mosi`. MOSI changes only on bit boundaries.
- R3: SPI runs in mode 0. SCLK is low whenever chip select is high. Each bit lasts `CLK_DIV` clocks: SCLK is low for the first `CLK_DIV/2` clocks of the bit and high for the rest.
- R4: Data bits are shifted in MSB first, and each bit is sampled in the last clock of its bit period. The k-th received byte, which is the EEPROM content at `SRC_OFFSET+k`, is written to SRAM address `DST_BASE+k`.
- R5: Each byte gets exactly one write strobe. Address and data are driven one cycle before `sram_we_n` goes low and stay unchanged during that cycle. `sram_we_n` is low for exactly one cycle. The strobe for byte k falls 2 cycles after its last bit is sampled, and one copy produces exactly `IMG_BYTES` strobes.
- R6: In the cycle after the last strobe, `spi_cs_n` goes to 1, `spi_oe` goes to 0 and `cpu_be` goes to 1. `cpu_res_n` stays 0 for two cycles, counting that one, and then rises together with `done`, while `busy` falls.
- R7: `done` first reads 1 after exactly (32 + 8·`IMG_BYTES`)·`CLK_DIV` + 5 rising clock edges, counted from reset release or from the start of a copy.
- R8: When `restart` is sampled high, the next cycle shows `done` = 0, `busy` = 1, `cpu_res_n` = 0, `cpu_be` = 0 and `spi_cs_n` = 1 for one pause cycle. A new copy then starts from the first byte and the first destination address, whether the restart came during a copy or after completion.
- R9: Once done, the engine stays done until restart. It issues no write strobe, keeps `spi_oe` at 0 and `spi_cs_n` at 1, and keeps SCLK low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low engine reset |
| restart | input | 1 | Synchronous request to re-run the copy with the processor held in reset |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_oe | output | 1 | 1: pads drive SCLK/MOSI/CS; 0: pads released (high impedance) |
| sram_addr | output | 19 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| cpu_res_n | output | 1 | Processor reset, active low |
| cpu_be | output | 1 | Processor bus enable, 1 lets the processor drive the bus |
| done | output | 1 | Copy complete and processor released |
| busy | output | 1 | Copy or release sequence in progress |

## Verification
The assertions check on every cycle the rules that hold in every cycle: SCLK stays low while chip select is high, each write strobe is one cycle long with stable address and data, the processor stays in reset until done, the bus and SPI are handed back when reset is released, restart forces the held state, and the done state stays stable. Only the bench scenarios can show the rest. These are the exact command bits on MOSI, the byte values and destination addresses written from the modelled EEPROM, the exact cycle in which each strobe falls and in which `done` rises, and a clean rerun after a restart in the middle of a copy and after completion.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;

   localparam int unsigned   SRAM_AW     = 19;
   localparam int unsigned   CMD_BITS    = 32;
   localparam logic [7:0]    READ_OPCODE = 8'h03;

   typedef enum logic [1:0] {
      SEQ_PAUSE,
      SEQ_XFER,
      SEQ_HOLD,
      SEQ_DONE
   } seq_state_e;

   typedef enum logic [1:0] {
      WR_IDLE,
      WR_SETUP,
      WR_STROBE
   } wr_state_e;

endpackage

// File: rtl/spi_stream_reader.sv
module spi_stream_reader
   import boot_copy_pkg::*;
#(
   parameter int unsigned CLK_DIV    = 4,
   parameter int unsigned IMG_BYTES  = 256,
   parameter logic [23:0] SRC_OFFSET = 24'h010000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       run,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       byte_valid,
   output logic [7:0] byte_data
);

   localparam int unsigned TOTAL_BITS = CMD_BITS + 8 * IMG_BYTES;
   localparam int unsigned BW         = $clog2(TOTAL_BITS + 1);
   localparam int unsigned DW         = $clog2(CLK_DIV);
   localparam int unsigned HALF       = CLK_DIV / 2;
   localparam logic [31:0] CMD_WORD   = {READ_OPCODE, SRC_OFFSET};

   logic [DW-1:0] div_q;
   logic [BW-1:0] bit_q;
   logic [31:0]   cmd_q;
   logic [7:0]    rx_q;
   logic          fin_q;
   logic          bv_q;
   logic [7:0]    bd_q;
   logic          active;
   logic          bit_end;
   logic          in_data;

   assign active  = run & ~fin_q;
   assign bit_end = active && (div_q == DW'(CLK_DIV - 1));
   assign in_data = (bit_q >= BW'(CMD_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         bit_q <= '0;
         cmd_q <= CMD_WORD;
         rx_q  <= '0;
         fin_q <= 1'b0;
         bv_q  <= 1'b0;
         bd_q  <= '0;
      end else if (clear) begin
         div_q <= '0;
         bit_q <= '0;
         cmd_q <= CMD_WORD;
         rx_q  <= '0;
         fin_q <= 1'b0;
         bv_q  <= 1'b0;
         bd_q  <= '0;
      end else begin
         bv_q <= 1'b0;
         if (active) begin
            div_q <= bit_end ? '0 : div_q + 1'b1;
            if (bit_end) begin
               rx_q  <= {rx_q[6:0], miso};
               cmd_q <= {cmd_q[30:0], 1'b0};
               bit_q <= bit_q + 1'b1;
               if (in_data && (bit_q[2:0] == 3'd7)) begin
                  bv_q <= 1'b1;
                  bd_q <= {rx_q[6:0], miso};
               end
               if (bit_q == BW'(TOTAL_BITS - 1)) begin
                  fin_q <= 1'b1;
               end
            end
         end
      end
   end

   generate
      if (HALF == 1) begin : g_sclk_lsb
         assign sclk = active & div_q[0];
      end else begin : g_sclk_cmp
         assign sclk = active & (div_q >= DW'(HALF));
      end
   endgenerate

   assign mosi       = in_data ? 1'b0 : cmd_q[31];
   assign byte_valid = bv_q;
   assign byte_data  = bd_q;

endmodule

// File: rtl/sram_byte_writer.sv
module sram_byte_writer
   import boot_copy_pkg::*;
#(
   parameter int unsigned          IMG_BYTES = 256,
   parameter logic [SRAM_AW-1:0]   DST_BASE  = 19'h00200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               byte_valid,
   input  logic [7:0]         byte_data,
   output logic [SRAM_AW-1:0] sram_addr,
   output logic [7:0]         sram_wdata,
   output logic               sram_we_n,
   output logic               last_strobe
);

   localparam int unsigned CW = $clog2(IMG_BYTES + 1);

   wr_state_e          st_q;
   logic [SRAM_AW-1:0] addr_q;
   logic [7:0]         data_q;
   logic [CW-1:0]      cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WR_IDLE;
         addr_q <= DST_BASE;
         data_q <= '0;
         cnt_q  <= '0;
      end else if (clear) begin
         st_q   <= WR_IDLE;
         addr_q <= DST_BASE;
         data_q <= '0;
         cnt_q  <= '0;
      end else begin
         case (st_q)
            WR_IDLE: begin
               if (byte_valid) begin
                  data_q <= byte_data;
                  st_q   <= WR_SETUP;
               end
            end
            WR_SETUP: begin
               st_q <= WR_STROBE;
            end
            WR_STROBE: begin
               st_q   <= WR_IDLE;
               addr_q <= addr_q + 1'b1;
               cnt_q  <= cnt_q + 1'b1;
            end
            default: begin
               st_q <= WR_IDLE;
            end
         endcase
      end
   end

   assign sram_addr   = addr_q;
   assign sram_wdata  = data_q;
   assign sram_we_n   = (st_q != WR_STROBE);
   assign last_strobe = (st_q == WR_STROBE) && (cnt_q == CW'(IMG_BYTES - 1));

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
   import boot_copy_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic last_strobe,
   output logic run,
   output logic clear,
   output logic spi_cs_n,
   output logic spi_oe,
   output logic cpu_res_n,
   output logic cpu_be,
   output logic done,
   output logic busy
);

   localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

   seq_state_e    st_q;
   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_XFER;
         hold_q <= '0;
      end else if (restart) begin
         st_q   <= SEQ_PAUSE;
         hold_q <= '0;
      end else begin
         case (st_q)
            SEQ_PAUSE: st_q <= SEQ_XFER;
            SEQ_XFER: begin
               if (last_strobe) begin
                  st_q   <= SEQ_HOLD;
                  hold_q <= '0;
               end
            end
            SEQ_HOLD: begin
               if (hold_q == HW'(HOLD_CYCLES - 1)) begin
                  st_q <= SEQ_DONE;
               end else begin
                  hold_q <= hold_q + 1'b1;
               end
            end
            SEQ_DONE: st_q <= SEQ_DONE;
            default:  st_q <= SEQ_PAUSE;
         endcase
      end
   end

   assign clear     = restart;
   assign run       = (st_q == SEQ_XFER);
   assign spi_cs_n  = (st_q != SEQ_XFER);
   assign spi_oe    = (st_q == SEQ_PAUSE) || (st_q == SEQ_XFER);
   assign cpu_be    = (st_q == SEQ_HOLD) || (st_q == SEQ_DONE);
   assign cpu_res_n = (st_q == SEQ_DONE);
   assign done      = (st_q == SEQ_DONE);
   assign busy      = (st_q != SEQ_DONE);

endmodule

// File: rtl/spi_boot_copier.sv
module spi_boot_copier
   import boot_copy_pkg::*;
#(
   parameter int unsigned          IMG_BYTES   = 256,
   parameter logic [23:0]          SRC_OFFSET  = 24'h010000,
   parameter logic [SRAM_AW-1:0]   DST_BASE    = 19'h00200,
   parameter int unsigned          CLK_DIV     = 4,
   parameter int unsigned          HOLD_CYCLES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               spi_miso,
   output logic               spi_sclk,
   output logic               spi_mosi,
   output logic               spi_cs_n,
   output logic               spi_oe,
   output logic [SRAM_AW-1:0] sram_addr,
   output logic [7:0]         sram_wdata,
   output logic               sram_we_n,
   output logic               cpu_res_n,
   output logic               cpu_be,
   output logic               done,
   output logic               busy
);

   localparam longint unsigned ADDR_SPAN = 64'd1 << SRAM_AW;
   localparam longint unsigned DST_END   = longint'(DST_BASE) + longint'(IMG_BYTES);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("spi_boot_copier: CLK_DIV must be even and at least 2");
      end
      if (IMG_BYTES < 1) begin : g_bad_len
         $error("spi_boot_copier: IMG_BYTES must be at least 1");
      end
      if (DST_END > ADDR_SPAN) begin : g_bad_dst
         $error("spi_boot_copier: destination range exceeds SRAM space");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("spi_boot_copier: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic       run;
   logic       clear;
   logic       byte_valid;
   logic [7:0] byte_data;
   logic       last_strobe;

   boot_sequencer #(
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (restart),
      .last_strobe (last_strobe),
      .run         (run),
      .clear       (clear),
      .spi_cs_n    (spi_cs_n),
      .spi_oe      (spi_oe),
      .cpu_res_n   (cpu_res_n),
      .cpu_be      (cpu_be),
      .done        (done),
      .busy        (busy)
   );

   spi_stream_reader #(
      .CLK_DIV    (CLK_DIV),
      .IMG_BYTES  (IMG_BYTES),
      .SRC_OFFSET (SRC_OFFSET)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .run        (run),
      .miso       (spi_miso),
      .sclk       (spi_sclk),
      .mosi       (spi_mosi),
      .byte_valid (byte_valid),
      .byte_data  (byte_data)
   );

   sram_byte_writer #(
      .IMG_BYTES (IMG_BYTES),
      .DST_BASE  (DST_BASE)
   ) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .byte_valid  (byte_valid),
      .byte_data   (byte_data),
      .sram_addr   (sram_addr),
      .sram_wdata  (sram_wdata),
      .sram_we_n   (sram_we_n),
      .last_strobe (last_strobe)
   );

endmodule

// File: rtl/spi_boot_copier_checker.sv
module spi_boot_copier_checker #(
   parameter int unsigned AW = 19
) (
   input logic          clk,
   input logic          rst_n,
   input logic          restart,
   input logic          spi_sclk,
   input logic          spi_cs_n,
   input logic          spi_oe,
   input logic [AW-1:0] sram_addr,
   input logic [7:0]    sram_wdata,
   input logic          sram_we_n,
   input logic          cpu_res_n,
   input logic          cpu_be,
   input logic          done,
   input logic          busy
);

   assert_cpu_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!cpu_res_n && busy));

   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   assert_write_owns_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!cpu_be && !cpu_res_n && !spi_cs_n));

   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |=> sram_we_n);

   assert_strobe_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_wdata)));

   assert_release_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_res_n) |-> ($past(cpu_be) && $past(cpu_be, 2) && !$past(spi_oe)));

   assert_released_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_res_n |-> (cpu_be && spi_cs_n && !spi_oe));

   assert_restart_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!done && busy && !cpu_res_n && !cpu_be && spi_cs_n && spi_oe));

   assert_done_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !restart) |=> (done && sram_we_n && !spi_oe && !spi_sclk));

endmodule

bind spi_boot_copier spi_boot_copier_checker #(
   .AW (19)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .spi_sclk   (spi_sclk),
   .spi_cs_n   (spi_cs_n),
   .spi_oe     (spi_oe),
   .sram_addr  (sram_addr),
   .sram_wdata (sram_wdata),
   .sram_we_n  (sram_we_n),
   .cpu_res_n  (cpu_res_n),
   .cpu_be     (cpu_be),
   .done       (done),
   .busy       (busy)
);

// File: tb/tb_spi_boot_copier.sv
`timescale 1ns/1ps
module tb_spi_boot_copier;

   localparam int          N     = 6;
   localparam int          CD    = 4;
   localparam logic [23:0] SRC   = 24'h0123FD;
   localparam logic [18:0] DST   = 19'h1FFFD;
   localparam int          TBITS = 32 + 8 * N;
   localparam int          TDONE = TBITS * CD + 5;
   localparam logic [31:0] CMDW  = {8'h03, SRC};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic        spi_miso = 1'b0;
   logic        spi_sclk, spi_mosi, spi_cs_n, spi_oe;
   logic [18:0] sram_addr;
   logic [7:0]  sram_wdata;
   logic        sram_we_n, cpu_res_n, cpu_be, done, busy;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int wr_seen  = 0;

   always #4 clk = ~clk;

   spi_boot_copier #(
      .IMG_BYTES  (N),
      .SRC_OFFSET (SRC),
      .DST_BASE   (DST),
      .CLK_DIV    (CD)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .spi_miso   (spi_miso),
      .spi_sclk   (spi_sclk),
      .spi_mosi   (spi_mosi),
      .spi_cs_n   (spi_cs_n),
      .spi_oe     (spi_oe),
      .sram_addr  (sram_addr),
      .sram_wdata (sram_wdata),
      .sram_we_n  (sram_we_n),
      .cpu_res_n  (cpu_res_n),
      .cpu_be     (cpu_be),
      .done       (done),
      .busy       (busy)
   );

   function automatic logic [7:0] ee_byte(input logic [23:0] a);
      return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cyc %0d)", req, what, act, exp, cyc);
      end
   endtask

   // Behavioural EEPROM
   logic [31:0] ee_cmd = '0;
   int          ee_cnt = 0;
   int          ee_idx;
   logic [7:0]  ee_val;

   always @(negedge spi_cs_n) ee_cnt = 0;

   always @(posedge spi_sclk) begin
      if (!spi_cs_n) begin
         if (ee_cnt < 32) ee_cmd = {ee_cmd[30:0], spi_mosi};
         ee_cnt++;
         if (ee_cnt == 32) begin
            check("R2", "opcode", {24'h0, ee_cmd[31:24]}, 32'h03);
            check("R2", "source offset", {8'h0, ee_cmd[23:0]}, {8'h0, SRC});
         end
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n && ee_cnt >= 32) begin
         ee_idx = ee_cnt - 32;
         ee_val = ee_byte(ee_cmd[23:0] + 24'(ee_idx / 8));
         spi_miso <= #1 ee_val[7 - (ee_idx % 8)];
      end
   end

   // Cycle counter of the reference model
   always @(posedge clk) begin
      if (!rst_n)       cyc <= 0;
      else if (restart) cyc <= -1;
      else              cyc <= cyc + 1;
   end

   // Cycle-by-cycle reference comparison
   always @(negedge clk) begin
      if (rst_n) begin
         automatic logic e_sclk = (cyc >= 0 && cyc < TBITS * CD) ? ((cyc % CD) >= CD / 2) : 1'b0;
         automatic logic e_cs_n = !(cyc >= 0 && cyc < TDONE - 2);
         automatic logic e_oe   = (cyc < TDONE - 2);
         automatic logic e_be   = (cyc >= TDONE - 2);
         automatic logic e_rel  = (cyc >= TDONE);
         automatic int   d      = cyc - 2 - 32 * CD;
         automatic int   j      = -1;
         if (d > 0 && (d % (8 * CD)) == 0 && (d / (8 * CD)) <= N) j = d / (8 * CD) - 1;
         check("R3", "sclk", {31'h0, spi_sclk}, {31'h0, e_sclk});
         check("R2", "cs_n", {31'h0, spi_cs_n}, {31'h0, e_cs_n});
         check("R9", "spi_oe", {31'h0, spi_oe}, {31'h0, e_oe});
         check("R6", "cpu_be", {31'h0, cpu_be}, {31'h0, e_be});
         check("R1", "cpu_res_n", {31'h0, cpu_res_n}, {31'h0, e_rel});
         check("R7", "done", {31'h0, done}, {31'h0, e_rel});
         check("R1", "busy", {31'h0, busy}, {31'h0, !e_rel});
         check("R5", "we_n", {31'h0, sram_we_n}, {31'h0, (j < 0)});
         if (cyc >= 0 && cyc < 32 * CD)
            check("R2", "mosi", {31'h0, spi_mosi}, {31'h0, CMDW[31 - cyc / CD]});
         if (j >= 0) begin
            check("R4", "sram_addr", {13'h0, sram_addr}, {13'h0, DST + 19'(j)});
            check("R4", "sram_wdata", {24'h0, sram_wdata}, {24'h0, ee_byte(SRC + 24'(j))});
         end
         if (!sram_we_n) wr_seen++;
      end
   end

   task automatic run_to(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   task automatic pulse_restart();
      @(negedge clk);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      wr_seen = 0;
      // R8: the pause cycle right after restart
      check("R8", "done after restart", {31'h0, done}, 32'h0);
      check("R8", "cpu_res_n after restart", {31'h0, cpu_res_n}, 32'h0);
      check("R8", "cpu_be after restart", {31'h0, cpu_be}, 32'h0);
      check("R8", "cs_n in pause", {31'h0, spi_cs_n}, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state while engine reset is held
      check("R1", "reset cpu_res_n", {31'h0, cpu_res_n}, 32'h0);
      check("R1", "reset cpu_be", {31'h0, cpu_be}, 32'h0);
      check("R1", "reset done", {31'h0, done}, 32'h0);
      check("R1", "reset busy", {31'h0, busy}, 32'h1);
      check("R5", "reset we_n", {31'h0, sram_we_n}, 32'h1);
      rst_n = 1'b1;

      // Restart in the middle of the third byte
      run_to(32 * CD + 16 * CD + 3);
      pulse_restart();
      run_to(TDONE + 12);
      check("R5", "strobes in rerun", wr_seen, N);
      check("R7", "done after rerun", {31'h0, done}, 32'h1);
      check("R9", "address parked", {13'h0, sram_addr}, {13'h0, DST + 19'(N)});

      // Restart after completion
      pulse_restart();
      run_to(TDONE + 20);
      check("R5", "strobes after late restart", wr_seen, N);
      check("R6", "cpu running again", {31'h0, cpu_res_n & cpu_be}, 32'h1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule